// File: doc/BRIEF.md
# Centered-Residue Polynomial Norm and Sum Reducer

This block folds one polynomial into a single 24-bit scalar while the coefficients stream past, one per clock. Every coefficient is first mapped to its centered residue: the unique value congruent to it modulo q that lies in the symmetric interval from −(q−1)/2 to +(q−1)/2. In norm mode the block keeps the largest absolute centered value seen, which gives the infinity norm. In sum mode it adds the centered values in a wide signed accumulator. After the last coefficient it reduces that total into [0, q).

A lattice-arithmetic engine uses it to test the size of error polynomials and to form coefficient checksums. The controller pulses `start` with the mode, modulus and length selected. It then presents the coefficients with `coef_valid`, which may have gaps, and waits for the one-cycle `done` pulse. Coefficients must already lie in [0, q), and q must be odd.

Top module: `poly_norm_reducer`

## Requirements
- R1: A coefficient c with c ≤ (q−1)/2 is taken as +c. A coefficient with c > (q−1)/2 is taken as c − q. For example, (q+1)/2 becomes −(q−1)/2.
- R2: With `mode_sum` = 0, the result is the largest |centered value| over the polynomial. It is never above (q−1)/2.
- R3: With `mode_sum` = 1, the result is the sum of the centered values reduced modulo q. It is given in [0, q), so a negative total t yields t mod q + q when t mod q is nonzero.
- R4: `len_sel` picks the polynomial length n = 64·2^len_sel for codes 0 to 5 (64, 128, 256, 512, 1024, 2048). Exactly n accepted coefficients end the pass.
- R5: A `start` pulse clears the running maximum, the accumulator and the coefficient count. It does so even when a pass is in progress, so only coefficients after the latest `start` count.
- R6: `done` is high for exactly one cycle. In norm mode it rises in the clock cycle after the last coefficient is accepted. In sum mode it rises 35 cycles later than that (36 cycles after the last coefficient), one cycle per magnitude bit of the 36-bit accumulator.
- R7: Coefficient cycles with `coef_valid` low, and any coefficients offered while the block is idle, have no effect on the result.
- R8: After reset, `done`, `busy` and `result` are 0. `result` is always below q when `done` is high, and it holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new pass; captures mode, modulus and length |
| mode_sum | input | 1 | 0 = maximum magnitude, 1 = modular sum |
| modulus | input | 24 | Odd modulus q |
| len_sel | input | 3 | Length code, n = 64 << len_sel |
| coef_valid | input | 1 | Coefficient on `coef` is offered this cycle |
| coef | input | 24 | Coefficient in [0, q) |
| busy | output | 1 | Pass or final reduction in progress |
| done | output | 1 | One-cycle pulse, `result` is valid |
| result | output | 24 | Reduced scalar in [0, q) |

## Verification
The bench keeps the default widths: 24-bit coefficients and an accumulator sized for 2048 terms. This makes the real moduli from 3329 up to 8404993 usable as they are. Most passes use the 64-coefficient length, so every length code, both modes and the centering boundary patterns can be swept over several moduli in a short run. These patterns are all-zero, all at (q−1)/2, all at (q+1)/2, and alternating 0 and q−1. Full-length 2048-term sums with the largest modulus drive the accumulator to its extreme magnitude and push the final reduction through all of its bits. Valid gaps, garbage offered while idle and a restarted pass are covered as well.

// File: rtl/poly_norm_reducer.sv
module poly_norm_reducer #(
  parameter int CW   = 24,
  parameter int LMAX = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_sum,
  input  logic [CW-1:0] modulus,
  input  logic [2:0]    len_sel,
  input  logic          coef_valid,
  input  logic [CW-1:0] coef,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] result
);
  localparam int AW = CW + LMAX + 1;
  localparam int MW = AW - 1;
  localparam int RW = CW + 1;
  localparam int BW = $clog2(MW + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_RED} st_t;

  st_t                  st;
  logic                 mode_r, neg;
  logic [CW-1:0]        q_r, run_max;
  logic [LMAX-1:0]      idx, last_idx;
  logic signed [AW-1:0] acc;
  logic [MW-1:0]        mag;
  logic [CW-1:0]        rem;
  logic [BW-1:0]        bitc;

  logic [CW-1:0]        half, mag_c, max_nx, fin;
  logic                 over, take, is_last;
  logic signed [AW-1:0] cent, acc_nx, acc_abs;
  logic [RW-1:0]        rem_sh, rem_nx;
  logic [LMAX:0]        n_len;

  assign half    = (q_r - 1'b1) >> 1;
  assign over    = coef > half;
  assign mag_c   = over ? q_r - coef : coef;
  assign cent    = over ? -$signed(AW'(mag_c)) : $signed(AW'(coef));
  assign acc_nx  = acc + cent;
  assign acc_abs = acc_nx[AW-1] ? -acc_nx : acc_nx;
  assign max_nx  = (mag_c > run_max) ? mag_c : run_max;
  assign take    = (st == S_RUN) && coef_valid;
  assign is_last = idx == last_idx;
  assign n_len   = (LMAX+1)'(64) << len_sel;

  assign rem_sh  = {rem, mag[MW-1]};
  assign rem_nx  = (rem_sh >= RW'(q_r)) ? rem_sh - RW'(q_r) : rem_sh;
  assign fin     = rem_nx[CW-1:0];
  assign busy    = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_r   <= 1'b0;
      neg      <= 1'b0;
      q_r      <= '0;
      run_max  <= '0;
      idx      <= '0;
      last_idx <= '0;
      acc      <= '0;
      mag      <= '0;
      rem      <= '0;
      bitc     <= '0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st       <= S_RUN;
        mode_r   <= mode_sum;
        q_r      <= modulus;
        last_idx <= LMAX'(n_len - 1'b1);
        idx      <= '0;
        run_max  <= '0;
        acc      <= '0;
      end else begin
        case (st)
          S_RUN: if (take) begin
            idx     <= idx + 1'b1;
            run_max <= max_nx;
            acc     <= acc_nx;
            if (is_last) begin
              if (mode_r) begin
                st   <= S_RED;
                mag  <= acc_abs[MW-1:0];
                neg  <= acc_nx[AW-1];
                rem  <= '0;
                bitc <= '0;
              end else begin
                st     <= S_IDLE;
                done   <= 1'b1;
                result <= max_nx;
              end
            end
          end
          S_RED: begin
            rem  <= fin;
            mag  <= mag << 1;
            bitc <= bitc + 1'b1;
            if (bitc == BW'(MW - 1)) begin
              st     <= S_IDLE;
              done   <= 1'b1;
              result <= (neg && fin != '0) ? q_r - fin : fin;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result < q_r);

  // R2
  max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_r) |-> result <= half);

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> idx <= last_idx);

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == S_RUN && idx == '0 && acc == '0 && run_max == '0));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result) || done);
endmodule

// File: tb/poly_norm_reducer_tb.sv
module poly_norm_reducer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode_sum = 1'b0, coef_valid = 1'b0;
  logic [23:0] modulus = 24'd3329, coef = '0;
  logic [2:0]  len_sel = '0;
  logic        busy, done;
  logic [23:0] result;

  int checks = 0, errors = 0;
  int cycles = 0;
  int coefs[2048];

  always #2.5 clk = ~clk;

  poly_norm_reducer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sum(mode_sum),
    .modulus(modulus), .len_sel(len_sel), .coef_valid(coef_valid),
    .coef(coef), .busy(busy), .done(done), .result(result));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill(input int kind, input int q, input int n);
    int h;
    h = (q - 1) / 2;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: coefs[i] = 0;
        1: coefs[i] = h;
        2: coefs[i] = h + 1;
        3: coefs[i] = int'($urandom % q);
        default: coefs[i] = (i % 2 == 0) ? 0 : q - 1;
      endcase
    end
  endtask

  task automatic pass(input string req, input bit msum, input int q,
                      input int ls, input int gap, input int prefix);
    int n, h, lat;
    longint s, m, c, ex;
    n = 64 << ls;
    h = (q - 1) / 2;
    s = 0; m = 0;
    for (int i = 0; i < n; i++) begin
      c = (coefs[i] > h) ? longint'(coefs[i]) - q : longint'(coefs[i]);
      s += c;
      if ((c < 0 ? -c : c) > m) m = (c < 0 ? -c : c);
    end
    ex = msum ? (((s % q) + q) % q) : m;
    @(negedge clk);
    start = 1'b1; mode_sum = msum; modulus = 24'(q); len_sel = 3'(ls);
    @(negedge clk);
    start = 1'b0;
    // R5: partial pass discarded by a second start
    for (int i = 0; i < prefix; i++) begin
      coef_valid = 1'b1; coef = 24'(q - 1 - i);
      @(negedge clk);
    end
    if (prefix > 0) begin
      start = 1'b1;
      coef_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        coef_valid = 1'b0; coef = 24'($urandom % q);
        @(negedge clk);
      end
      coef_valid = 1'b1; coef = 24'(coefs[i]);
      @(negedge clk);
    end
    coef_valid = 1'b0; coef = 24'(h + 1);
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(req, result, ex);
    check("R6 latency", lat, msum ? 36 : 1);
    check("R8 range", result < q, 1);
    @(negedge clk);
    check("R6 pulse width", done, 0);
    check("R8 hold", result, ex);
  endtask

  initial begin
    int qs[5];
    qs[0] = 3329; qs[1] = 7681; qs[2] = 12289; qs[3] = 8380417; qs[4] = 8404993;
    #1;
    check("R8 reset done", done, 0);
    check("R8 reset busy", busy, 0);
    check("R8 reset result", result, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: garbage while idle
    for (int i = 0; i < 5; i++) begin
      coef_valid = 1'b1; coef = 24'd1000 + 24'(i);
      @(negedge clk);
    end
    coef_valid = 1'b0;
    check("R7 idle busy", busy, 0);
    check("R7 idle done", done, 0);
    for (int qi = 0; qi < 5; qi++) begin
      for (int k = 0; k < 5; k++) begin
        fill(k, qs[qi], 64);
        pass("R1 R2 max mode", 1'b0, qs[qi], 0, 0, 0);
        pass("R1 R3 sum mode", 1'b1, qs[qi], 0, 0, 0);
      end
    end
    for (int ls = 0; ls < 6; ls++) begin
      fill(3, 7681, 64 << ls);
      pass("R4 length max", 1'b0, 7681, ls, 0, 0);
      pass("R4 length sum", 1'b1, 7681, ls, 0, 0);
    end
    fill(1, 8404993, 2048);
    pass("R3 extreme positive", 1'b1, 8404993, 5, 0, 0);
    fill(2, 8404993, 2048);
    pass("R3 extreme negative", 1'b1, 8404993, 5, 0, 0);
    fill(3, 12289, 64);
    pass("R7 valid gaps max", 1'b0, 12289, 0, 2, 0);
    pass("R7 valid gaps sum", 1'b1, 12289, 0, 3, 0);
    fill(0, 3329, 64);
    pass("R5 restart max", 1'b0, 3329, 0, 0, 10);
    fill(3, 3329, 64);
    pass("R5 restart sum", 1'b1, 3329, 0, 1, 7);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule